// File: doc/BRIEF.md
# Flash Erase-Block Select Guard

This block holds the erase-block selection for a flash array of twelve blocks with uneven sizes. Software picks one block by writing a bit into one of two 8-bit select registers. The lower register covers blocks 0 to 7 and the upper register covers blocks 8 to 11. At most one bit may be set across both registers. A write that breaks this rule, or that sets a reserved bit, wipes the whole selection.

The selection is also cleared by reset, by either standby mode, by the write-enable pin going low, and while the software write enable is off. When on-chip flash is disabled, reads return zero and writes have no effect.

The block also decodes a 24-bit flash address into its erase block. It raises `erase_allowed` only when that block is the one selected and the software write enable is on. The erase sequencer uses this flag to gate its erase pulses.

Top module: `erase_block_guard`

## Requirements
- R1: Register offset 0 holds blocks 7..0 in bits 7..0. Offset 1 holds blocks 11..8 in bits 3..0, and its bits 7..4 always read 0. A write takes effect at the clock edge that samples `reg_we`, and `reg_rdata` is combinational on `reg_addr`.
- R2: Any of the following clears both registers to 0x00 at the next clock edge: `rst` high, `hw_standby` high, `sw_standby` high, or `wr_enable_pin` low.
- R3: While `sw_wr_en` is low, the registers are held at 0x00, and a write cannot set any bit.
- R4: A write whose result, combined across both registers, would have more than one bit set clears both registers to 0x00. This includes a write to one register while a bit is set in the other.
- R5: A write to offset 1 with any of bits 7..4 set to 1 clears both registers to 0x00.
- R6: While `flash_en` is low, `reg_rdata` is 0x00 and writes are ignored. The earlier selection reads back unchanged once `flash_en` returns high.
- R7: Address decode: 0x000000–0x007FFF gives blocks 0–7 in 4 kB steps (index = address bits 14..12). 0x008000–0x00FFFF gives block 8. 0x010000, 0x020000 and 0x030000 each start a 64 kB block, giving 9, 10 and 11.
- R8: For addresses at or above 0x040000, `blk_valid` is low and `blk_index` is 0.
- R9: `erase_allowed` is high only when `blk_valid` is high, the addressed block's select bit is the single set bit, and `sw_wr_en` is high.
- R10: A single-bit write to the register that already holds the selected bit replaces that selection with the new bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| hw_standby | input | 1 | Hardware standby mode active |
| sw_standby | input | 1 | Software standby mode active |
| wr_enable_pin | input | 1 | Flash write-enable pin level |
| sw_wr_en | input | 1 | Software write-enable control bit |
| flash_en | input | 1 | On-chip flash enabled |
| reg_addr | input | 1 | Register offset (0 lower, 1 upper) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| flash_addr | input | 24 | Flash address to classify |
| blk_index | output | 4 | Erase block index of `flash_addr` |
| blk_valid | output | 1 | `flash_addr` lies inside the erase map |
| erase_allowed | output | 1 | Addressed block may be erased |

## Verification
The assertions assume that `rst` is high from time zero until the first edges have passed. They also assume that every control input is a clean level, sampled once per rising edge.

The bench meets these assumptions. It holds reset at the start and changes every input only on falling edges, so each control level is stable around the edge that samples it. Each standby or pin condition is applied for one whole cycle and then released before the next check.

Writes are issued one per strobe, with no back-to-back overlap. This lets every post-write read observe the result of exactly one register update.

// File: rtl/esel_pkg.sv
package esel_pkg;
    localparam int REG_W      = 8;
    localparam int NUM_BLK    = 12;
    localparam int NUM_REGS   = (NUM_BLK + REG_W - 1) / REG_W;
    localparam int PAD_W      = NUM_REGS * REG_W;
    localparam int RA_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int IDX_W      = $clog2(NUM_BLK);
    localparam int FADDR_W    = 24;
    localparam int SMALL_LOG  = 12;
    localparam int SMALL_CNT  = 8;
    localparam int SMALL_END  = SMALL_LOG + $clog2(SMALL_CNT);
    localparam int MID_IDX    = SMALL_CNT;
    localparam int LARGE_LOG  = 16;
    localparam int LARGE_END  = LARGE_LOG + 2;

    typedef logic [NUM_BLK-1:0] blk_mask_t;
    typedef logic [PAD_W-1:0]   reg_image_t;

    typedef struct packed {
        logic             we;
        logic [RA_W-1:0]  addr;
        logic [REG_W-1:0] data;
    } reg_wr_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             valid;
    } blk_hit_t;

    typedef enum logic [1:0] {
        CLR_NONE  = 2'd0,
        CLR_POWER = 2'd1,
        CLR_MODE  = 2'd2,
        CLR_GUARD = 2'd3
    } clr_cause_e;

    function automatic blk_hit_t decode_addr(input logic [FADDR_W-1:0] a);
        blk_hit_t h;
        h.valid = ((a >> LARGE_END) == '0);
        if (!h.valid)
            h.idx = '0;
        else if ((a >> SMALL_END) == '0)
            h.idx = IDX_W'(a >> SMALL_LOG);
        else if ((a >> LARGE_LOG) == '0)
            h.idx = IDX_W'(MID_IDX);
        else
            h.idx = IDX_W'(MID_IDX) + IDX_W'(a >> LARGE_LOG);
        return h;
    endfunction

    function automatic int unsigned bit_count(input blk_mask_t m);
        int unsigned n = 0;
        for (int i = 0; i < NUM_BLK; i++) n += int'(m[i]);
        return n;
    endfunction
endpackage

// File: rtl/esel_clear_ctrl.sv
module esel_clear_ctrl
    import esel_pkg::*;
(
    input  logic       rst,
    input  logic       hw_standby,
    input  logic       sw_standby,
    input  logic       wr_enable_pin,
    input  logic       sw_wr_en,
    output clr_cause_e cause
);
    always_comb begin
        if (rst)
            cause = CLR_POWER;
        else if (hw_standby || sw_standby)
            cause = CLR_MODE;
        else if (!wr_enable_pin || !sw_wr_en)
            cause = CLR_GUARD;
        else
            cause = CLR_NONE;
    end
endmodule

// File: rtl/esel_regs.sv
module esel_regs
    import esel_pkg::*;
(
    input  logic             clk,
    input  clr_cause_e       cause,
    input  logic             flash_en,
    input  reg_wr_t          wr,
    input  logic [RA_W-1:0]  rd_addr,
    output logic [REG_W-1:0] rd_data,
    output blk_mask_t        sel_mask
);
    blk_mask_t  sel_q;
    blk_mask_t  sel_nxt;
    reg_image_t cur_img;
    reg_image_t new_img;
    logic       bad_write;
    logic [REG_W-1:0] view [NUM_REGS];

    assign cur_img = reg_image_t'(sel_q);

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_view
            assign view[r] = cur_img[r*REG_W +: REG_W];
        end
    endgenerate

    always_comb begin
        new_img   = cur_img;
        bad_write = 1'b0;
        sel_nxt   = sel_q;
        if (wr.we && flash_en) begin
            new_img[wr.addr*REG_W +: REG_W] = wr.data;
            bad_write = (new_img[PAD_W-1:NUM_BLK] != '0) ||
                        (bit_count(new_img[NUM_BLK-1:0]) > 1);
            sel_nxt   = bad_write ? '0 : new_img[NUM_BLK-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (cause != CLR_NONE)
            sel_q <= '0;
        else
            sel_q <= sel_nxt;
    end

    assign rd_data  = flash_en ? view[rd_addr] : '0;
    assign sel_mask = sel_q;
endmodule

// File: rtl/esel_addr_decode.sv
module esel_addr_decode
    import esel_pkg::*;
(
    input  logic [FADDR_W-1:0] addr,
    output blk_hit_t           hit
);
    assign hit = decode_addr(addr);
endmodule

// File: rtl/erase_block_guard.sv
module erase_block_guard
    import esel_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                hw_standby,
    input  logic                sw_standby,
    input  logic                wr_enable_pin,
    input  logic                sw_wr_en,
    input  logic                flash_en,
    input  logic [RA_W-1:0]     reg_addr,
    input  logic                reg_we,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [FADDR_W-1:0]  flash_addr,
    output logic [IDX_W-1:0]    blk_index,
    output logic                blk_valid,
    output logic                erase_allowed
);
    clr_cause_e cause;
    reg_wr_t    wr;
    blk_mask_t  sel_mask;
    blk_hit_t   hit;
    logic       hit_sel;

    assign wr = '{we: reg_we, addr: reg_addr, data: reg_wdata};

    esel_clear_ctrl u_clr (
        .rst           (rst),
        .hw_standby    (hw_standby),
        .sw_standby    (sw_standby),
        .wr_enable_pin (wr_enable_pin),
        .sw_wr_en      (sw_wr_en),
        .cause         (cause)
    );

    esel_regs u_regs (
        .clk      (clk),
        .cause    (cause),
        .flash_en (flash_en),
        .wr       (wr),
        .rd_addr  (reg_addr),
        .rd_data  (reg_rdata),
        .sel_mask (sel_mask)
    );

    esel_addr_decode u_dec (
        .addr (flash_addr),
        .hit  (hit)
    );

    always_comb begin
        hit_sel = 1'b0;
        for (int b = 0; b < NUM_BLK; b++)
            if (hit.idx == IDX_W'(b)) hit_sel = sel_mask[b];
    end

    assign blk_index     = hit.idx;
    assign blk_valid     = hit.valid;
    assign erase_allowed = hit.valid && hit_sel && sw_wr_en &&
                           (bit_count(sel_mask) == 1);
endmodule

// File: rtl/esel_checker.sv
module esel_checker
    import esel_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               hw_standby,
    input logic               sw_standby,
    input logic               wr_enable_pin,
    input logic               sw_wr_en,
    input logic               flash_en,
    input logic [RA_W-1:0]    reg_addr,
    input logic               reg_we,
    input logic [REG_W-1:0]   reg_wdata,
    input logic [REG_W-1:0]   reg_rdata,
    input logic [FADDR_W-1:0] flash_addr,
    input logic               blk_valid,
    input logic               erase_allowed,
    input blk_mask_t          sel_mask
);
    logic clr_cond;
    assign clr_cond = hw_standby || sw_standby || !wr_enable_pin || !sw_wr_en;

    p_single_sel_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_mask));

    p_clear_on_mode_r2: assert property (@(posedge clk) disable iff (rst)
        clr_cond |=> (sel_mask == '0));

    p_swe_low_r3: assert property (@(posedge clk) disable iff (rst)
        !sw_wr_en |=> (sel_mask == '0));

    p_reserved_wipe_r5: assert property (@(posedge clk) disable iff (rst)
        (flash_en && reg_we && reg_addr == RA_W'(1) &&
         reg_wdata[REG_W-1:NUM_BLK-REG_W] != '0) |=> (sel_mask == '0));

    p_disabled_read_r6: assert property (@(posedge clk) disable iff (rst)
        !flash_en |-> (reg_rdata == '0));

    p_disabled_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!flash_en && !clr_cond) |=> $stable(sel_mask));

    p_out_of_map_r8: assert property (@(posedge clk) disable iff (rst)
        (flash_addr >= FADDR_W'(24'h040000)) |-> !blk_valid);

    p_erase_gate_r9: assert property (@(posedge clk) disable iff (rst)
        erase_allowed |-> (sw_wr_en && blk_valid && $countones(sel_mask) == 1));
endmodule

bind erase_block_guard esel_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .hw_standby    (hw_standby),
    .sw_standby    (sw_standby),
    .wr_enable_pin (wr_enable_pin),
    .sw_wr_en      (sw_wr_en),
    .flash_en      (flash_en),
    .reg_addr      (reg_addr),
    .reg_we        (reg_we),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .flash_addr    (flash_addr),
    .blk_valid     (blk_valid),
    .erase_allowed (erase_allowed),
    .sel_mask      (sel_mask)
);

// File: tb/erase_block_guard_test.sv
module erase_block_guard_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_standby = 1'b0;
    logic        sw_standby = 1'b0;
    logic        wr_enable_pin = 1'b1;
    logic        sw_wr_en = 1'b1;
    logic        flash_en = 1'b1;
    logic [0:0]  reg_addr = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [23:0] flash_addr = 24'h0;
    logic [3:0]  blk_index;
    logic        blk_valid;
    logic        erase_allowed;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    erase_block_guard uut (
        .clk (clk), .rst (rst), .hw_standby (hw_standby), .sw_standby (sw_standby),
        .wr_enable_pin (wr_enable_pin), .sw_wr_en (sw_wr_en), .flash_en (flash_en),
        .reg_addr (reg_addr), .reg_we (reg_we), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .flash_addr (flash_addr), .blk_index (blk_index),
        .blk_valid (blk_valid), .erase_allowed (erase_allowed)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, int'(reg_rdata), int'(exp));
    endtask

    task automatic clear_all();
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_reset();
        rd_check("R2 reset lower", 1'b0, 8'h00);
        rd_check("R2 reset upper", 1'b1, 8'h00);
    endtask

    task automatic t_layout();
        wr(1'b0, 8'h04);
        rd_check("R1 lower write", 1'b0, 8'h04);
        rd_check("R1 upper untouched", 1'b1, 8'h00);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h02);
        rd_check("R1 upper write", 1'b1, 8'h02);
        rd_check("R1 lower clear", 1'b0, 8'h00);
    endtask

    task automatic t_replace();
        wr(1'b1, 8'h04);
        rd_check("R10 upper replaced", 1'b1, 8'h04);
        wr(1'b0, 8'h00);
        wr(1'b0, 8'h80);
        wr(1'b0, 8'h01);
        rd_check("R10 lower replaced", 1'b0, 8'h01);
    endtask

    task automatic t_two_bits();
        clear_all();
        wr(1'b1, 8'h04);
        wr(1'b0, 8'h01);
        rd_check("R4 cross lower", 1'b0, 8'h00);
        rd_check("R4 cross upper", 1'b1, 8'h00);
        wr(1'b0, 8'h03);
        rd_check("R4 same register", 1'b0, 8'h00);
    endtask

    task automatic t_reserved();
        clear_all();
        wr(1'b1, 8'h01);
        wr(1'b1, 8'h11);
        rd_check("R5 reserved with bit", 1'b1, 8'h00);
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h80);
        rd_check("R5 reserved wipes lower", 1'b0, 8'h00);
    endtask

    task automatic t_clears();
        for (int k = 0; k < 4; k++) begin
            wr(1'b0, 8'h20);
            @(negedge clk);
            case (k)
                0: hw_standby = 1'b1;
                1: sw_standby = 1'b1;
                2: wr_enable_pin = 1'b0;
                default: rst = 1'b1;
            endcase
            @(negedge clk);
            hw_standby = 1'b0; sw_standby = 1'b0; wr_enable_pin = 1'b1; rst = 1'b0;
            rd_check($sformatf("R2 clear cause %0d", k), 1'b0, 8'h00);
        end
    endtask

    task automatic t_swe();
        @(negedge clk);
        sw_wr_en = 1'b0;
        wr(1'b0, 8'h01);
        rd_check("R3 write blocked", 1'b0, 8'h00);
        sw_wr_en = 1'b1;
        wr(1'b0, 8'h40);
        sw_wr_en = 1'b0;
        @(negedge clk);
        sw_wr_en = 1'b1;
        rd_check("R3 held clear", 1'b0, 8'h00);
    endtask

    task automatic t_disabled();
        wr(1'b0, 8'h08);
        flash_en = 1'b0;
        rd_check("R6 read zero", 1'b0, 8'h00);
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h01);
        flash_en = 1'b1;
        rd_check("R6 lower kept", 1'b0, 8'h08);
        rd_check("R6 upper kept", 1'b1, 8'h00);
    endtask

    task automatic dec(input logic [23:0] a, input int idx, input bit v);
        flash_addr = a;
        #1;
        check(v ? "R7 index" : "R8 index", int'(blk_index), idx);
        check(v ? "R7 valid" : "R8 valid", int'(blk_valid), int'(v));
    endtask

    task automatic t_decode();
        dec(24'h000000, 0, 1'b1);  dec(24'h000FFF, 0, 1'b1);
        dec(24'h001000, 1, 1'b1);  dec(24'h005ABC, 5, 1'b1);
        dec(24'h007FFF, 7, 1'b1);  dec(24'h008000, 8, 1'b1);
        dec(24'h00FFFF, 8, 1'b1);  dec(24'h010000, 9, 1'b1);
        dec(24'h01FFFF, 9, 1'b1);  dec(24'h020000, 10, 1'b1);
        dec(24'h030000, 11, 1'b1); dec(24'h03FFFF, 11, 1'b1);
        dec(24'h040000, 0, 1'b0);  dec(24'hFFFFFF, 0, 1'b0);
    endtask

    task automatic ea(input string req, input logic [23:0] a, input bit exp);
        flash_addr = a;
        #1;
        check(req, int'(erase_allowed), int'(exp));
    endtask

    task automatic t_erase();
        clear_all();
        wr(1'b0, 8'h08);
        ea("R9 selected block", 24'h003000, 1'b1);
        ea("R9 other block", 24'h004000, 1'b0);
        sw_wr_en = 1'b0;
        ea("R9 swe low", 24'h003000, 1'b0);
        @(negedge clk);
        sw_wr_en = 1'b1;
        wr(1'b1, 8'h01);
        ea("R9 block 8", 24'h00C000, 1'b1);
        wr(1'b1, 8'h08);
        ea("R9 block 11", 24'h035555, 1'b1);
        ea("R9 outside map", 24'h045555, 1'b0);
        ea("R9 block 9", 24'h015555, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_layout();
        t_replace();
        t_two_bits();
        t_reserved();
        t_clears();
        t_swe();
        t_disabled();
        t_decode();
        t_erase();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule